// File: doc/BRIEF.md
# External Interrupt Sense and Latch Controller

This block watches up to 32 external interrupt pins and turns each into a clean, level-style interrupt line for a host interrupt controller. Each pin is first brought into the clock domain by a flop synchronizer. It is then judged against a sense mode chosen per channel: active-low level, active-high level, rising edge, falling edge, or either edge. A match latches a per-channel detect bit. That bit drives the channel's output line whenever the channel is enabled. The line stays high until software clears the latch, so downstream logic can treat every channel as a level interrupt.

Software reaches the block through a plain 32-bit register port with separate read and write strobes. Reads are combinational while the read strobe is high. Writes take effect at the clock edge that samples the write strobe. The detect latches are cleared by writing ones. Enables are turned on through one register and turned off through another, and the second register also returns the enable vector. A monitor register shows the synchronized pin levels, and a request register shows which enabled channels are pending.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset, every enable bit, detect bit and channel configuration is 0, every output line is low, and the request, enable, detect and configuration registers read 0.
- R2: The configuration of channel n is at byte offset 0x180 + 4*n. A write stores bits 5:0 of the data, and a read returns those 6 bits with bits 31:6 at 0.
- R3: Mode 0x01 latches the detect bit on every cycle in which the synchronized pin is 0, and mode 0x02 does so on every cycle in which it is 1. A clear while the level is still present is therefore followed by a fresh detection.
- R4: Mode 0x04 latches on a synchronized 1-to-0 transition, mode 0x08 on a 0-to-1 transition, and mode 0x0C on either. After a pin change, the detect bit is visible following the third rising clock edge (two synchronizer edges, then one latch edge).
- R5: Configuration code 0x00, and any code not listed in R3 or R4, never sets the detect bit.
- R6: The detect register is at 0x100, with bit n belonging to channel n. Writing 1 to a bit clears that latch and writing 0 leaves it unchanged. A detection in the same cycle as a clear leaves the bit set.
- R7: Writing 1 to bit n at 0x008 enables channel n, and writing 1 to bit n at 0x004 disables it. Zero bits have no effect, and reading 0x004 returns the enable vector.
- R8: Output line n is high exactly while channel n is both latched and enabled. The request register at 0x000 reads the same vector, so a latched but disabled channel keeps its detect bit with its line low.
- R9: The monitor register at 0x104 returns the synchronized level of every pin, two clock edges after the pin level.
- R10: While the read strobe is low, or the address matches no register, the read data is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| irq_pin_i | input | NUM_CH | External interrupt pins, asynchronous to clk |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | ADDR_W | Register byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid while bus_rd_i is high |
| irq_o | output | NUM_CH | Per-channel level interrupt lines |

## Verification
On every cycle, the checker confirms four things. A detect bit may fall only in the cycle after a detect-register write that carried a 1 for it. An enable bit may change only after a matching set or clear write. The request register and the monitor register agree with the output lines and the delayed pins. The read data is 0 whenever the strobe is low. Whether a given mode fires on the right level or transition is shown only by the bench's scenarios: the table of mode, start level and end level, the level re-latch after a clear, and the clear that collides with an edge in the same cycle.

// File: rtl/eic_pkg.sv
package eic_pkg;
   localparam int OFS_REQ    = 'h000;
   localparam int OFS_EN_CLR = 'h004;
   localparam int OFS_EN_SET = 'h008;
   localparam int OFS_DET    = 'h100;
   localparam int OFS_MON    = 'h104;
   localparam int OFS_CFG    = 'h180;
   localparam int CFG_W      = 6;

   localparam logic [CFG_W-1:0] SENSE_LOW  = 6'h01;
   localparam logic [CFG_W-1:0] SENSE_HIGH = 6'h02;
   localparam logic [CFG_W-1:0] SENSE_FALL = 6'h04;
   localparam logic [CFG_W-1:0] SENSE_RISE = 6'h08;
   localparam logic [CFG_W-1:0] SENSE_ANY  = 6'h0C;

   function automatic logic sense_hit(input logic [CFG_W-1:0] mode,
                                      input logic cur, input logic prv);
      logic h;
      case (mode)
         SENSE_LOW:  h = ~cur;
         SENSE_HIGH: h = cur;
         SENSE_FALL: h = prv & ~cur;
         SENSE_RISE: h = ~prv & cur;
         SENSE_ANY:  h = prv ^ cur;
         default:    h = 1'b0;
      endcase
      return h;
   endfunction
endpackage

// File: rtl/eic_sync.sv
module eic_sync #(
   parameter int W      = 32,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("eic_sync: STAGES must be at least 2");
   end

   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < STAGES; k++) stg[k] <= '0;
      end else begin
         stg[0] <= d_i;
         for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
      end
   end

   assign q_o = stg[STAGES-1];
endmodule

// File: rtl/eic_channel.sv
module eic_channel
   import eic_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lvl_i,
   input  logic             cfg_we_i,
   input  logic [CFG_W-1:0] cfg_wdata_i,
   input  logic             det_clr_i,
   input  logic             en_set_i,
   input  logic             en_clr_i,
   output logic [CFG_W-1:0] cfg_o,
   output logic             det_o,
   output logic             en_o
);
   logic [CFG_W-1:0] cfg_q;
   logic             prv_q;
   logic             det_q;
   logic             en_q;
   logic             hit;

   assign hit = sense_hit(cfg_q, lvl_i, prv_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= '0;
         prv_q <= 1'b0;
         det_q <= 1'b0;
         en_q  <= 1'b0;
      end else begin
         prv_q <= lvl_i;
         if (cfg_we_i) cfg_q <= cfg_wdata_i;
         // a detection in the clear cycle wins so no event is dropped
         det_q <= hit | (det_q & ~det_clr_i);
         if (en_set_i)      en_q <= 1'b1;
         else if (en_clr_i) en_q <= 1'b0;
      end
   end

   assign cfg_o = cfg_q;
   assign det_o = det_q;
   assign en_o  = en_q;
endmodule

// File: rtl/eic_regs.sv
module eic_regs
   import eic_pkg::*;
#(
   parameter int NUM_CH = 32,
   parameter int ADDR_W = 12
) (
   input  logic              wr_i,
   input  logic              rd_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [31:0]       wdata_i,
   input  logic [NUM_CH-1:0] det_i,
   input  logic [NUM_CH-1:0] en_i,
   input  logic [NUM_CH-1:0] lvl_i,
   input  logic [CFG_W-1:0]  cfg_i [NUM_CH],
   output logic [NUM_CH-1:0] cfg_we_o,
   output logic [NUM_CH-1:0] det_clr_o,
   output logic [NUM_CH-1:0] en_set_o,
   output logic [NUM_CH-1:0] en_clr_o,
   output logic [31:0]       rdata_o
);
   localparam logic [ADDR_W-1:0] A_REQ    = ADDR_W'(OFS_REQ);
   localparam logic [ADDR_W-1:0] A_EN_CLR = ADDR_W'(OFS_EN_CLR);
   localparam logic [ADDR_W-1:0] A_EN_SET = ADDR_W'(OFS_EN_SET);
   localparam logic [ADDR_W-1:0] A_DET    = ADDR_W'(OFS_DET);
   localparam logic [ADDR_W-1:0] A_MON    = ADDR_W'(OFS_MON);

   logic [NUM_CH-1:0] wmask;
   assign wmask = wdata_i[NUM_CH-1:0];

   assign det_clr_o = (wr_i && addr_i == A_DET)    ? wmask : '0;
   assign en_set_o  = (wr_i && addr_i == A_EN_SET) ? wmask : '0;
   assign en_clr_o  = (wr_i && addr_i == A_EN_CLR) ? wmask : '0;

   for (genvar n = 0; n < NUM_CH; n++) begin : g_cfg_dec
      localparam logic [ADDR_W-1:0] A_CFG = ADDR_W'(OFS_CFG + 4*n);
      assign cfg_we_o[n] = wr_i && (addr_i == A_CFG);
   end

   always_comb begin
      rdata_o = '0;
      if (rd_i) begin
         if (addr_i == A_REQ)    rdata_o = 32'(det_i & en_i);
         if (addr_i == A_EN_CLR) rdata_o = 32'(en_i);
         if (addr_i == A_DET)    rdata_o = 32'(det_i);
         if (addr_i == A_MON)    rdata_o = 32'(lvl_i);
         for (int n = 0; n < NUM_CH; n++) begin
            if (addr_i == ADDR_W'(OFS_CFG + 4*n)) rdata_o = 32'(cfg_i[n]);
         end
      end
   end
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
   import eic_pkg::*;
#(
   parameter int NUM_CH      = 32,
   parameter int ADDR_W      = 12,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] irq_pin_i,
   input  logic              bus_wr_i,
   input  logic              bus_rd_i,
   input  logic [ADDR_W-1:0] bus_addr_i,
   input  logic [31:0]       bus_wdata_i,
   output logic [31:0]       bus_rdata_o,
   output logic [NUM_CH-1:0] irq_o
);
   localparam int TOP_ADDR = OFS_CFG + 4*(NUM_CH-1);

   if (NUM_CH < 1 || NUM_CH > 32) begin : g_bad_ch
      $error("ext_irq_ctrl: NUM_CH must be 1..32");
   end
   if ((1 << ADDR_W) <= TOP_ADDR) begin : g_bad_addr
      $error("ext_irq_ctrl: ADDR_W too narrow for the register map");
   end

   logic [NUM_CH-1:0] lvl_vec;
   logic [NUM_CH-1:0] det_vec;
   logic [NUM_CH-1:0] en_vec;
   logic [NUM_CH-1:0] cfg_we;
   logic [NUM_CH-1:0] det_clr;
   logic [NUM_CH-1:0] en_set;
   logic [NUM_CH-1:0] en_clr;
   logic [CFG_W-1:0]  cfg_arr [NUM_CH];

   eic_sync #(.W(NUM_CH), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (irq_pin_i),
      .q_o   (lvl_vec)
   );

   eic_regs #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_regs (
      .wr_i      (bus_wr_i),
      .rd_i      (bus_rd_i),
      .addr_i    (bus_addr_i),
      .wdata_i   (bus_wdata_i),
      .det_i     (det_vec),
      .en_i      (en_vec),
      .lvl_i     (lvl_vec),
      .cfg_i     (cfg_arr),
      .cfg_we_o  (cfg_we),
      .det_clr_o (det_clr),
      .en_set_o  (en_set),
      .en_clr_o  (en_clr),
      .rdata_o   (bus_rdata_o)
   );

   for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
      eic_channel u_ch (
         .clk         (clk),
         .rst_n       (rst_n),
         .lvl_i       (lvl_vec[n]),
         .cfg_we_i    (cfg_we[n]),
         .cfg_wdata_i (bus_wdata_i[CFG_W-1:0]),
         .det_clr_i   (det_clr[n]),
         .en_set_i    (en_set[n]),
         .en_clr_i    (en_clr[n]),
         .cfg_o       (cfg_arr[n]),
         .det_o       (det_vec[n]),
         .en_o        (en_vec[n])
      );
   end

   assign irq_o = det_vec & en_vec;
endmodule

// File: rtl/eic_chk.sv
module eic_chk
   import eic_pkg::*;
#(
   parameter int NUM_CH = 32,
   parameter int ADDR_W = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic [NUM_CH-1:0] irq_pin_i,
   input logic              bus_wr_i,
   input logic              bus_rd_i,
   input logic [ADDR_W-1:0] bus_addr_i,
   input logic [31:0]       bus_wdata_i,
   input logic [31:0]       bus_rdata_o,
   input logic [NUM_CH-1:0] irq_o,
   input logic [NUM_CH-1:0] det_vec,
   input logic [NUM_CH-1:0] en_vec
);
   logic [1:0]        age;
   logic              det_wr, set_wr, clr_wr;
   logic [NUM_CH-1:0] wmask;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         age <= '0;
      else if (age != 2'd3) age <= age + 2'd1;
   end

   assign wmask  = bus_wdata_i[NUM_CH-1:0];
   assign det_wr = bus_wr_i && bus_addr_i == ADDR_W'(OFS_DET);
   assign set_wr = bus_wr_i && bus_addr_i == ADDR_W'(OFS_EN_SET);
   assign clr_wr = bus_wr_i && bus_addr_i == ADDR_W'(OFS_EN_CLR);

   // R1
   reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> irq_o == '0);

   // R6
   det_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|($past(det_vec) & ~det_vec)) |->
      ($past(det_wr) && (($past(det_vec) & ~det_vec & ~$past(wmask)) == '0)));

   // R7
   en_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|(~$past(en_vec) & en_vec)) |->
      ($past(set_wr) && ((~$past(en_vec) & en_vec & ~$past(wmask)) == '0)));

   // R7
   en_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|($past(en_vec) & ~en_vec)) |->
      ($past(clr_wr) && (($past(en_vec) & ~en_vec & ~$past(wmask)) == '0)));

   // R8
   req_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd_i && bus_addr_i == ADDR_W'(OFS_REQ)) |->
      bus_rdata_o == 32'(irq_o));

   // R9
   mon_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (age == 2'd3 && bus_rd_i && bus_addr_i == ADDR_W'(OFS_MON)) |->
      bus_rdata_o == 32'($past(irq_pin_i, 2)));

   // R10
   idle_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd_i |-> bus_rdata_o == '0);
endmodule

bind ext_irq_ctrl eic_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .irq_pin_i   (irq_pin_i),
   .bus_wr_i    (bus_wr_i),
   .bus_rd_i    (bus_rd_i),
   .bus_addr_i  (bus_addr_i),
   .bus_wdata_i (bus_wdata_i),
   .bus_rdata_o (bus_rdata_o),
   .irq_o       (irq_o),
   .det_vec     (det_vec),
   .en_vec      (en_vec)
);

// File: tb/ext_irq_ctrl_bench.sv
`timescale 1ns/1ps
module ext_irq_ctrl_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] pins = '0;
   logic        wr = 1'b0, rd = 1'b0;
   logic [11:0] addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic [31:0] irq;
   int n_chk = 0, n_fail = 0;
   logic [31:0] v;

   // row: mode[11:4], start[3], end[2], after-change[1], after-reclear[0]
   localparam int NV = 12;
   localparam logic [11:0] VEC [NV] = '{
      {8'h01, 1'b1, 1'b0, 1'b1, 1'b1},   // R3 low, goes active
      {8'h01, 1'b0, 1'b1, 1'b1, 1'b0},   // R3 low, leaves active
      {8'h02, 1'b0, 1'b1, 1'b1, 1'b1},   // R3 high, goes active
      {8'h02, 1'b1, 1'b0, 1'b1, 1'b0},   // R3 high, leaves active
      {8'h04, 1'b1, 1'b0, 1'b1, 1'b0},   // R4 falling
      {8'h04, 1'b0, 1'b1, 1'b0, 1'b0},   // R4 falling, wrong way
      {8'h08, 1'b0, 1'b1, 1'b1, 1'b0},   // R4 rising
      {8'h08, 1'b1, 1'b0, 1'b0, 1'b0},   // R4 rising, wrong way
      {8'h0C, 1'b0, 1'b1, 1'b1, 1'b0},   // R4 both, up
      {8'h0C, 1'b1, 1'b0, 1'b1, 1'b0},   // R4 both, down
      {8'h00, 1'b0, 1'b1, 1'b0, 1'b0},   // R5 off
      {8'h03, 1'b1, 1'b0, 1'b0, 1'b0}    // R5 unlisted code
   };

   always #2.5 clk = ~clk;

   ext_irq_ctrl u_ext_irq_ctrl (
      .clk(clk), .rst_n(rst_n), .irq_pin_i(pins),
      .bus_wr_i(wr), .bus_rd_i(rd), .bus_addr_i(addr),
      .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wreg(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk); wr = 1'b1; addr = a; wdata = d;
      @(negedge clk); wr = 1'b0;
   endtask

   task automatic rreg(input logic [11:0] a, output logic [31:0] d);
      @(negedge clk); rd = 1'b1; addr = a;
      #1 d = rdata;
      @(negedge clk); rd = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      #400000;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      idle(5);
      rst_n = 1'b1;
      idle(2);

      // R1 reset state
      chk("R1 irq", irq, 32'h0);
      rreg(12'h004, v); chk("R1 enable", v, 32'h0);
      rreg(12'h100, v); chk("R1 detect", v, 32'h0);
      rreg(12'h1FC, v); chk("R1 cfg31", v, 32'h0);
      rreg(12'h000, v); chk("R1 request", v, 32'h0);
      // R10 strobe low, unmapped address
      #1 chk("R10 idle rdata", rdata, 32'h0);
      rreg(12'h0F0, v); chk("R10 unmapped", v, 32'h0);

      // R2 config storage and readback
      wreg(12'h194, 32'hFFFF_FFC9);
      rreg(12'h194, v); chk("R2 cfg5", v, 32'h09);
      wreg(12'h1FC, 32'h0000_0002);
      rreg(12'h1FC, v); chk("R2 cfg31", v, 32'h02);

      // R7 enable set/clear
      wreg(12'h008, 32'h0000_0009);
      rreg(12'h004, v); chk("R7 set", v, 32'h9);
      wreg(12'h004, 32'h0000_0001);
      rreg(12'h004, v); chk("R7 clear", v, 32'h8);
      wreg(12'h008, 32'h0);
      rreg(12'h004, v); chk("R7 zero write", v, 32'h8);
      wreg(12'h008, 32'h8000_0000);
      rreg(12'h004, v); chk("R7 set msb", v, 32'h8000_0008);

      // R9 monitor
      @(negedge clk) pins = 32'h25A5_0000;
      idle(3);
      rreg(12'h104, v); chk("R9 monitor", v, 32'h25A5_0000);
      @(negedge clk) pins = 32'h0;
      idle(3);
      wreg(12'h100, 32'hFFFF_FFFF);
      rreg(12'h100, v); chk("R6 clear all", v, 32'h0);

      // R8 top channel, high level
      @(negedge clk) pins[31] = 1'b1;
      idle(4);
      chk("R8 irq31 on", irq, 32'h8000_0000);
      rreg(12'h000, v); chk("R8 request", v, 32'h8000_0000);
      wreg(12'h004, 32'h8000_0000);
      #1 chk("R8 disabled line low", irq, 32'h0);
      rreg(12'h100, v); chk("R8 latch kept", v & 32'h8000_0000, 32'h8000_0000);
      rreg(12'h000, v); chk("R8 request masked", v, 32'h0);
      @(negedge clk) pins[31] = 1'b0;
      idle(3);
      wreg(12'h100, 32'h8000_0000);

      // table walk on channel 3 (enabled)
      for (int i = 0; i < NV; i++) begin
         logic [7:0] md;
         logic [31:0] r;
         md = VEC[i][11:4];
         @(negedge clk) pins[3] = VEC[i][3];
         idle(4);
         wreg(12'h18C, {24'h0, md});
         wreg(12'h100, 32'h8);
         @(negedge clk) pins[3] = VEC[i][2];
         idle(5);
         rreg(12'h100, r);
         chk($sformatf("R3/R4/R5 row %0d detect", i), r & 32'h8, {28'h0, VEC[i][1], 3'b0});
         #1 chk($sformatf("R8 row %0d line", i), irq & 32'h8, {28'h0, VEC[i][1], 3'b0});
         wreg(12'h100, 32'h8);
         idle(3);
         rreg(12'h100, r);
         chk($sformatf("R3/R4/R5 row %0d reclear", i), r & 32'h8, {28'h0, VEC[i][0], 3'b0});
      end

      // R6 write of 0 leaves latch
      @(negedge clk) pins[3] = 1'b0;
      wreg(12'h18C, 32'h08);
      idle(3);
      wreg(12'h100, 32'h8);
      @(negedge clk) pins[3] = 1'b1;
      idle(4);
      wreg(12'h100, 32'hFFFF_FFF7);
      rreg(12'h100, v); chk("R6 zero write", v & 32'h8, 32'h8);

      // R6 clear colliding with a rising edge
      @(negedge clk) pins[3] = 1'b0;
      idle(4);
      wreg(12'h100, 32'h8);
      rreg(12'h100, v); chk("R6 cleared", v & 32'h8, 32'h0);
      @(negedge clk) pins[3] = 1'b1;
      @(negedge clk);
      @(negedge clk); wr = 1'b1; addr = 12'h100; wdata = 32'h8;
      @(negedge clk); wr = 1'b0;
      rreg(12'h100, v); chk("R6 set wins", v & 32'h8, 32'h8);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule